// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter made of 4-bit stages. Each stage can be preset in parallel and cleared by an active-low reset. It has two count enables. One enable is shared by every stage. The other enable is chained, so each stage passes a carry to the stage above it. A stage counts only when both enables are high. If either enable is low, the count holds.

The parameter `STAGES` sets how many nibble stages are chained, so the counter is 4*STAGES bits wide. All stages share the clock, the load strobe and the shared enable. The carry of each stage feeds the chained enable of the next more significant stage. The carry of the top stage leaves the block so that further chains can be cascaded.

The parameter `ASYNC_RESET` selects the reset style:
- When it is 1, reset clears the count immediately, without waiting for the clock.
- When it is 0, reset acts only on a rising clock edge.

Top module: `presettable_counter_chain`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count` becomes zero after that edge. Reset takes priority over load and over counting.
- R2: With `ASYNC_RESET`=1, a falling `rst_n` clears `count` to zero at once, without any clock edge.
- R3: With `ASYNC_RESET`=0, a falling `rst_n` between edges leaves `count` unchanged until the next rising edge clears it.
- R4: When `load_n` is low and `rst_n` is high at a rising edge, `count` takes the value of `preset`, whatever the enables are.
- R5: When `rst_n` and `load_n` are high and both `en_par` and `en_chain` are high at a rising edge, `count` increases by one.
- R6: When `rst_n` and `load_n` are high and either `en_par` or `en_chain` is low at a rising edge, `count` holds. Each enable alone is enough to inhibit counting.
- R7: The count wraps from 2^(4*STAGES)-1 to zero.
- R8: `carry_out` is combinational. It is high exactly when `en_chain` is high and every bit of `count` is one, and it does not depend on `en_par`.
- R9: A stage advances only when every less significant stage holds fifteen. For example, a 2-stage count goes from 0x0F to 0x10 in one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous per `ASYNC_RESET` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Count enable shared by all stages; does not gate the carry |
| en_chain | input | 1 | Count enable of the least significant stage; gates the carry |
| preset | input | 4*STAGES | Parallel preset value |
| count | output | 4*STAGES | Counter value |
| carry_out | output | 1 | Ripple carry of the most significant stage |

## Verification
The bench builds two instances and drives them with the same stimulus:
- The first has two stages and asynchronous reset. The 8-bit width lets it reach the carry from the low nibble into the high nibble (R9) and a full 256-step wrap of the whole chain (R7).
- The second has one stage and synchronous reset.

The bench drops reset halfway between clock edges. This shows that the first instance clears at once (R2) while the second waits for the next edge (R3). A reference model follows both instances on every edge.

// File: rtl/nibble_stage.sv
module nibble_stage #(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic       en_p,
  input  logic       en_t,
  input  logic [3:0] d,
  output logic [3:0] q,
  output logic       rco
);
  logic [3:0] q_next;

  assign q_next = !load_n        ? d :
                  (en_p && en_t) ? q + 4'd1 : q;
  assign rco    = en_t && (q == 4'hF);

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
  endgenerate
endmodule

// File: rtl/presettable_counter_chain.sv
module presettable_counter_chain #(
  parameter int STAGES      = 2,
  parameter bit ASYNC_RESET = 1'b1,
  localparam int W          = 4 * STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_chain,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count,
  output logic         carry_out
);
  logic [STAGES:0] carry;

  assign carry[0]  = en_chain;
  assign carry_out = carry[STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      nibble_stage #(.ASYNC_RESET(ASYNC_RESET)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .en_p   (en_par),
        .en_t   (carry[i]),
        .d      (preset[4*i +: 4]),
        .q      (count[4*i +: 4]),
        .rco    (carry[i+1])
      );
    end
  endgenerate
endmodule

// File: rtl/presettable_counter_chain_chk.sv
module presettable_counter_chain_chk #(
  parameter int STAGES      = 2,
  parameter bit ASYNC_RESET = 1'b1,
  localparam int W          = 4 * STAGES
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic         en_par,
  input logic         en_chain,
  input logic [W-1:0] preset,
  input logic [W-1:0] count,
  input logic         carry_out
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (count == '0));

  generate
    if (ASYNC_RESET) begin : g_async_chk
      p_async_clear_r2: assert property (@(posedge clk)
        !rst_n |-> (count == '0));
    end
  endgenerate

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (count == $past(preset)));

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_chain) |=> (count == W'($past(count) + 1'b1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_chain)) |=> $stable(count));

  p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == (en_chain && (&count)));
endmodule

bind presettable_counter_chain presettable_counter_chain_chk #(
  .STAGES(STAGES), .ASYNC_RESET(ASYNC_RESET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par),
  .en_chain(en_chain), .preset(preset), .count(count), .carry_out(carry_out)
);

// File: tb/tb_presettable_counter_chain.sv
module tb_presettable_counter_chain;
  logic clk = 1'b0;
  logic rst_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [7:0] preset = '0;
  logic [7:0] cnt_a;
  logic [3:0] cnt_s;
  logic       co_a, co_s;
  logic [7:0] m_a = '0;
  logic [3:0] m_s = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  presettable_counter_chain #(.STAGES(2), .ASYNC_RESET(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_p), .en_chain(en_t),
    .preset(preset), .count(cnt_a), .carry_out(co_a));

  presettable_counter_chain #(.STAGES(1), .ASYNC_RESET(1'b0)) dut_s (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_p), .en_chain(en_t),
    .preset(preset[3:0]), .count(cnt_s), .carry_out(co_s));

  // {rst_n, load_n, en_p, en_t, preset[7:0], expected count[7:0], expected carry}
  localparam logic [20:0] VEC [16] = '{
    {4'b0111, 8'h00, 8'h00, 1'b0},
    {4'b1011, 8'h0C, 8'h0C, 1'b0},
    {4'b1111, 8'h00, 8'h0D, 1'b0},
    {4'b1111, 8'h00, 8'h0E, 1'b0},
    {4'b1111, 8'h00, 8'h0F, 1'b0},
    {4'b1111, 8'h00, 8'h10, 1'b0},
    {4'b1111, 8'h00, 8'h11, 1'b0},
    {4'b1111, 8'h00, 8'h12, 1'b0},
    {4'b1101, 8'h00, 8'h12, 1'b0},
    {4'b1110, 8'h00, 8'h12, 1'b0},
    {4'b1011, 8'hFE, 8'hFE, 1'b0},
    {4'b1111, 8'h00, 8'hFF, 1'b1},
    {4'b1101, 8'h00, 8'hFF, 1'b1},
    {4'b1110, 8'h00, 8'hFF, 1'b0},
    {4'b1111, 8'h00, 8'h00, 1'b0},
    {4'b0011, 8'h55, 8'h00, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one rising edge, model update, compare at the following falling edge
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin m_a = '0; m_s = '0; end
    else if (!load_n) begin m_a = preset; m_s = preset[3:0]; end
    else if (en_p && en_t) begin m_a = m_a + 8'd1; m_s = m_s + 4'd1; end
    @(negedge clk);
    chk(cnt_a == m_a, "R5/R6 model 2-stage", cnt_a, m_a);
    chk(cnt_s == m_s, "R5/R6 model 1-stage", cnt_s, m_s);
    chk(co_a == (en_t && m_a == 8'hFF), "R8 carry 2-stage", co_a, en_t && m_a == 8'hFF);
    chk(co_s == (en_t && m_s == 4'hF), "R8 carry 1-stage", co_s, en_t && m_s == 4'hF);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    step();
    chk(cnt_a == 8'h00, "R1 reset state", cnt_a, 0);
    chk(cnt_s == 4'h0, "R1 reset state sync", cnt_s, 0);

    // vector walk: preset 12, count through 0x0F->0x10 (R9), inhibit, wrap (R7), reset over load (R1)
    for (int i = 0; i < 16; i++) begin
      {rst_n, load_n, en_p, en_t, preset} = VEC[i][20:9];
      step();
      chk(cnt_a == VEC[i][8:1], "R1/R4/R5/R6/R7/R9 vector", cnt_a, VEC[i][8:1]);
      chk(co_a == VEC[i][0], "R8 vector carry", co_a, VEC[i][0]);
    end

    // reset dropped between edges: R2 clears at once, R3 waits for the edge
    rst_n = 1'b1; load_n = 1'b0; preset = 8'h37; en_p = 1'b1; en_t = 1'b1;
    step();
    load_n = 1'b1; en_p = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    chk(cnt_a == 8'h00, "R2 async clear between edges", cnt_a, 0);
    chk(cnt_s == 4'h7, "R3 sync holds between edges", cnt_s, 7);
    @(posedge clk); #1;
    m_a = '0; m_s = '0;
    chk(cnt_s == 4'h0, "R3 sync cleared at edge", cnt_s, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // load wins over active enables
    load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; preset = 8'hA9;
    step();
    chk(cnt_a == 8'hA9, "R4 load with enables high", cnt_a, 8'hA9);

    // full-range run and wrap on both instances
    load_n = 1'b0; preset = 8'h00; step();
    load_n = 1'b1;
    for (int k = 0; k < 256; k++) step();
    chk(cnt_a == 8'h00, "R7 full wrap 2-stage", cnt_a, 0);

    // inhibit by each enable alone
    en_p = 1'b0; step(); step();
    en_p = 1'b1; en_t = 1'b0; step(); step();
    chk(cnt_a == 8'h00, "R6 inhibit each enable", cnt_a, 0);

    finish_run();
  end
endmodule